// File: doc/BRIEF.md
# Frame-Parity Periodic Request Queue

This block keeps the queue of pending periodic (interrupt OUT) token requests for a host controller and decides when each is released. Software streams packet words into the periodic transmit buffer. The word flagged as the final word of a packet also places a request entry in a small queue. The entry holds the channel number, the packet's position within its per-frame group, and the frame parity, odd or even, that the channel is configured for.

At every start of frame the block looks only at the head of the queue. If the head's parity agrees with the low bit of the new frame number, the block raises a token request for that channel. On each transmit acknowledgement it pops the head. It keeps issuing in the same frame while the following entry continues the same channel's multi-packet group. A per-channel remaining-packet counter, loaded when a transfer starts, produces a completion pulse when the final packet has been acknowledged. A full queue is flagged, and any packet end that arrives while the queue is full is refused with an error pulse.

Top module: `periodic_req_queue`

## Requirements
- R1: After reset the queue is empty: `q_full`, `tok_valid`, `xfer_cmpl` and `wr_err` are all low.
- R2: A write with `wr_valid` and `wr_last` both high, made while the queue is not full, enqueues one entry. The entry takes `chan_odd[wr_chan]` and the channel's current group index. Writes with `wr_last` low enqueue nothing.
- R3: The queue holds 4 entries, and `q_full` is high while it holds 4. A last-word write made while the queue is full leaves the queue unchanged and raises `wr_err` for one cycle, in the cycle after the write.
- R4: At a start-of-frame pulse, if the head entry's odd bit equals `frame_num[0]`, `tok_valid` rises in the next cycle. `tok_chan` and `tok_idx` then show the head's channel and group index.
- R5: If the head's parity differs from the frame, no token is issued in that frame. Entries behind the head are never served ahead of it.
- R6: A channel's group index counts 0, 1, … up to `chan_mc` minus 1 and then wraps to 0 (2-bit field; 0 is treated as 1). After an acknowledgement, issuing continues within the same frame only if the next entry has the same channel and a non-zero index. Otherwise `tok_valid` drops until a later start of frame.
- R7: `tx_done` while `tok_valid` is high pops the head. While no acknowledgement arrives, `tok_valid`, `tok_chan` and `tok_idx` hold steady.
- R8: `xfer_start` loads `xfer_pkts` as the remaining count of channel `xfer_chan`. The acknowledgement that takes this count from 1 to 0 gives a one-cycle `xfer_cmpl`, with `cmpl_chan` showing the channel, in the following cycle. A channel whose count is already 0 never completes.
- R9: `tx_done` while `tok_valid` is low has no effect on the queue or the counters.
- R10: `xfer_start` also resets that channel's group index to 0.
- R11: A start-of-frame pulse carrying the same frame number as the last accepted one is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Packet word write strobe |
| wr_last | input | 1 | Marks the final word of a packet |
| wr_chan | input | CH_W | Channel of the word being written |
| chan_odd | input | NUM_CH | Per-channel odd-frame select |
| chan_mc | input | 2*NUM_CH | Per-channel packets-per-frame count, 2 bits each |
| xfer_start | input | 1 | Starts a transfer on `xfer_chan` |
| xfer_chan | input | CH_W | Channel being started |
| xfer_pkts | input | PKT_W | Packet count of the transfer |
| sof | input | 1 | Start-of-frame pulse |
| frame_num | input | FN_W | Frame number given with `sof` |
| tx_done | input | 1 | Transmit acknowledgement of the current token |
| tok_valid | output | 1 | OUT token request pending |
| tok_chan | output | CH_W | Channel of the token request |
| tok_idx | output | 2 | Group index of the token request |
| xfer_cmpl | output | 1 | Transfer complete pulse |
| cmpl_chan | output | CH_W | Channel that completed |
| q_full | output | 1 | Request queue full |
| wr_err | output | 1 | Packet end refused because the queue was full |

## Verification
The bench sends the head entry into frames of the wrong parity and places a matching entry behind it. A design that reorders the queue or ignores parity issues a token the scoreboard does not expect. Three-packet and zero-count groups check that a burst stops at a group boundary: a design that drains the whole channel in one frame, or treats a count of 0 as 0, shows extra or missing tokens. A fifth packet end on a full queue, a stray acknowledgement with no token pending, a repeated frame number and a restart in the middle of a group each have a wrong outcome at the ports. That outcome is an extra token, a lost entry, a missing error pulse, or a group index that does not restart at 0.

// File: rtl/prq_pkg.sv
package prq_pkg;
  localparam int unsigned MC_W = 2;

  typedef enum logic {
    SCH_IDLE = 1'b0,
    SCH_SEND = 1'b1
  } sch_state_e;

  function automatic logic [MC_W-1:0] mc_norm(input logic [MC_W-1:0] mc);
    return (mc == '0) ? MC_W'(1) : mc;
  endfunction
endpackage

// File: rtl/prq_fifo.sv
module prq_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned EW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] push_data,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic          head_valid,
  output logic [EW-1:0] nxt,
  output logic          nxt_valid,
  output logic          full
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [EW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d, rptr_p1;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    rptr_p1 = ptr_inc(rptr_q);
    wptr_d  = push ? ptr_inc(wptr_q) : wptr_q;
    rptr_d  = pop  ? rptr_p1 : rptr_q;
    cnt_d   = cnt_q;
    if (push && !pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
  end

  assign head       = mem[rptr_q];
  assign nxt        = mem[rptr_p1];
  assign head_valid = (cnt_q != '0);
  assign nxt_valid  = (cnt_q > CNT_W'(1));
  assign full       = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/prq_grpidx.sv
module prq_grpidx #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [CH_W-1:0]            wr_chan,
  input  logic [NUM_CH*prq_pkg::MC_W-1:0] chan_mc,
  input  logic                       xfer_start,
  input  logic [CH_W-1:0]            xfer_chan,
  output logic [prq_pkg::MC_W-1:0]   cur_idx
);
  import prq_pkg::*;

  logic [MC_W-1:0] idx_q [NUM_CH];
  logic [MC_W-1:0] idx_d [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [MC_W-1:0] mc_eff;
    logic [MC_W-1:0] idx_inc;
    assign mc_eff  = mc_norm(chan_mc[c*MC_W +: MC_W]);
    assign idx_inc = idx_q[c] + MC_W'(1);

    always_comb begin
      idx_d[c] = idx_q[c];
      if (xfer_start && (xfer_chan == CH_W'(c)))
        idx_d[c] = '0;
      else if (push && (wr_chan == CH_W'(c)))
        idx_d[c] = (idx_inc >= mc_eff) ? '0 : idx_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q[c] <= '0;
      else        idx_q[c] <= idx_d[c];
    end
  end

  assign cur_idx = idx_q[wr_chan];
endmodule

// File: rtl/prq_sched.sv
module prq_sched #(
  parameter int unsigned CH_W = 2,
  parameter int unsigned FN_W = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sof,
  input  logic [FN_W-1:0]          frame_num,
  input  logic                     head_valid,
  input  logic [CH_W-1:0]          head_chan,
  input  logic [prq_pkg::MC_W-1:0] head_idx,
  input  logic                     head_odd,
  input  logic                     nxt_valid,
  input  logic [CH_W-1:0]          nxt_chan,
  input  logic [prq_pkg::MC_W-1:0] nxt_idx,
  input  logic                     nxt_odd,
  input  logic                     tx_done,
  output logic                     send,
  output logic                     pop
);
  import prq_pkg::*;

  sch_state_e      st_q, st_d;
  logic            par_q, par_d;
  logic [FN_W-1:0] fn_q, fn_d;
  logic            fn_vld_q, fn_vld_d;
  logic            sof_ok, cont;

  assign sof_ok = sof && !(fn_vld_q && (frame_num == fn_q));
  assign cont   = nxt_valid && (nxt_chan == head_chan) &&
                  (nxt_idx != '0) && (nxt_odd == par_q);
  assign send   = (st_q == SCH_SEND);
  assign pop    = send && tx_done;

  always_comb begin
    st_d     = st_q;
    par_d    = par_q;
    fn_d     = fn_q;
    fn_vld_d = fn_vld_q;
    if (sof_ok) begin
      fn_d     = frame_num;
      fn_vld_d = 1'b1;
    end
    case (st_q)
      SCH_IDLE: begin
        if (sof_ok && head_valid && (head_odd == frame_num[0])) begin
          st_d  = SCH_SEND;
          par_d = frame_num[0];
        end
      end
      SCH_SEND: begin
        if (tx_done) st_d = cont ? SCH_SEND : SCH_IDLE;
      end
      default: st_d = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SCH_IDLE;
      par_q    <= 1'b0;
      fn_q     <= '0;
      fn_vld_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      par_q    <= par_d;
      fn_q     <= fn_d;
      fn_vld_q <= fn_vld_d;
    end
  end

  logic unused_hidx;
  assign unused_hidx = ^head_idx;
endmodule

// File: rtl/prq_cmpl.sv
module prq_cmpl #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2,
  parameter int unsigned PKT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_start,
  input  logic [CH_W-1:0]  xfer_chan,
  input  logic [PKT_W-1:0] xfer_pkts,
  input  logic             done,
  input  logic [CH_W-1:0]  done_chan,
  output logic             cmpl,
  output logic [CH_W-1:0]  cmpl_chan
);
  logic [PKT_W-1:0] rem_q [NUM_CH];
  logic [PKT_W-1:0] rem_d [NUM_CH];
  logic [NUM_CH-1:0] hit;
  logic              cmpl_d;
  logic [CH_W-1:0]   cchan_d;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ld, dec;
    assign ld  = xfer_start && (xfer_chan == CH_W'(c));
    assign dec = done && (done_chan == CH_W'(c)) && (rem_q[c] != '0);
    assign hit[c] = dec && !ld && (rem_q[c] == PKT_W'(1));

    always_comb begin
      rem_d[c] = rem_q[c];
      if (ld)       rem_d[c] = xfer_pkts;
      else if (dec) rem_d[c] = rem_q[c] - PKT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rem_q[c] <= '0;
      else        rem_q[c] <= rem_d[c];
    end
  end

  assign cmpl_d  = |hit;
  assign cchan_d = done_chan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl      <= 1'b0;
      cmpl_chan <= '0;
    end else begin
      cmpl <= cmpl_d;
      if (cmpl_d) cmpl_chan <= cchan_d;
    end
  end
endmodule

// File: rtl/periodic_req_queue.sv
module periodic_req_queue #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned PKT_W  = 8,
  parameter int unsigned FN_W   = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic                     wr_last,
  input  logic [CH_W-1:0]          wr_chan,
  input  logic [NUM_CH-1:0]        chan_odd,
  input  logic [NUM_CH*2-1:0]      chan_mc,
  input  logic                     xfer_start,
  input  logic [CH_W-1:0]          xfer_chan,
  input  logic [PKT_W-1:0]         xfer_pkts,
  input  logic                     sof,
  input  logic [FN_W-1:0]          frame_num,
  input  logic                     tx_done,
  output logic                     tok_valid,
  output logic [CH_W-1:0]          tok_chan,
  output logic [1:0]               tok_idx,
  output logic                     xfer_cmpl,
  output logic [CH_W-1:0]          cmpl_chan,
  output logic                     q_full,
  output logic                     wr_err
);
  import prq_pkg::*;

  localparam int unsigned EW      = CH_W + MC_W + 1;
  localparam int unsigned IDX_LSB = CH_W;
  localparam int unsigned ODD_BIT = CH_W + MC_W;

  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic          push, pop, send, err_d;
  logic [EW-1:0] push_data, head, nxt;
  logic          head_valid, nxt_valid, full;
  logic [MC_W-1:0] cur_idx;

  assign push      = wr_valid && wr_last && !full;
  assign err_d     = wr_valid && wr_last && full;
  assign push_data = {chan_odd[wr_chan], cur_idx, wr_chan};

  prq_grpidx #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_idx (
    .clk(clk), .rst_n(rst_sn), .push(push), .wr_chan(wr_chan),
    .chan_mc(chan_mc), .xfer_start(xfer_start), .xfer_chan(xfer_chan),
    .cur_idx(cur_idx)
  );

  prq_fifo #(.DEPTH(DEPTH), .EW(EW)) u_fifo (
    .clk(clk), .rst_n(rst_sn), .push(push), .push_data(push_data),
    .pop(pop), .head(head), .head_valid(head_valid), .nxt(nxt),
    .nxt_valid(nxt_valid), .full(full)
  );

  prq_sched #(.CH_W(CH_W), .FN_W(FN_W)) u_sched (
    .clk(clk), .rst_n(rst_sn), .sof(sof), .frame_num(frame_num),
    .head_valid(head_valid), .head_chan(head[CH_W-1:0]),
    .head_idx(head[IDX_LSB +: MC_W]), .head_odd(head[ODD_BIT]),
    .nxt_valid(nxt_valid), .nxt_chan(nxt[CH_W-1:0]),
    .nxt_idx(nxt[IDX_LSB +: MC_W]), .nxt_odd(nxt[ODD_BIT]),
    .tx_done(tx_done), .send(send), .pop(pop)
  );

  prq_cmpl #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PKT_W(PKT_W)) u_cmpl (
    .clk(clk), .rst_n(rst_sn), .xfer_start(xfer_start),
    .xfer_chan(xfer_chan), .xfer_pkts(xfer_pkts), .done(pop),
    .done_chan(head[CH_W-1:0]), .cmpl(xfer_cmpl), .cmpl_chan(cmpl_chan)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) wr_err <= 1'b0;
    else         wr_err <= err_d;
  end

  assign tok_valid = send;
  assign tok_chan  = send ? head[CH_W-1:0] : '0;
  assign tok_idx   = send ? head[IDX_LSB +: MC_W] : '0;
  assign q_full    = full;
endmodule

// File: rtl/periodic_req_queue_chk.sv
module periodic_req_queue_chk #(
  parameter int unsigned CH_W = 2,
  parameter int unsigned FN_W = 11
) (
  input logic            clk,
  input logic            rst_sn,
  input logic            wr_valid,
  input logic            wr_last,
  input logic            sof,
  input logic [FN_W-1:0] frame_num,
  input logic            tx_done,
  input logic            tok_valid,
  input logic [CH_W-1:0] tok_chan,
  input logic [1:0]      tok_idx,
  input logic            xfer_cmpl,
  input logic            q_full,
  input logic            hd_odd
);
  // R3: a refused packet end leaves a full queue full
  a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_sn)
    (q_full && wr_valid && wr_last && !(tok_valid && tx_done)) |=> q_full);

  // R4: a new token only follows a start of frame
  a_r4_tok_after_sof: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(tok_valid) |-> $past(sof));

  // R5: a burst only begins on an entry whose parity matches the frame
  a_r5_parity_match: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(tok_valid) |-> (hd_odd == $past(frame_num[0])));

  // R7: token fields hold until acknowledged
  a_r7_tok_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (tok_valid && !tx_done) |=> (tok_valid && $stable(tok_chan) && $stable(tok_idx)));

  // R8: completion only after an accepted acknowledgement
  a_r8_cmpl_after_ack: assert property (@(posedge clk) disable iff (!rst_sn)
    xfer_cmpl |-> $past(tok_valid && tx_done));
endmodule

bind periodic_req_queue periodic_req_queue_chk #(.CH_W(CH_W), .FN_W(FN_W)) u_chk (
  .clk(clk), .rst_sn(rst_sn), .wr_valid(wr_valid), .wr_last(wr_last),
  .sof(sof), .frame_num(frame_num), .tx_done(tx_done),
  .tok_valid(tok_valid), .tok_chan(tok_chan), .tok_idx(tok_idx),
  .xfer_cmpl(xfer_cmpl), .q_full(q_full), .hd_odd(u_fifo.head[CH_W+2])
);

// File: tb/periodic_req_queue_tb.sv
module periodic_req_queue_tb;
  localparam int NUM_CH = 4;
  localparam int CH_W   = 2;
  localparam int PKT_W  = 8;
  localparam int FN_W   = 11;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_valid, wr_last;
  logic [CH_W-1:0] wr_chan;
  logic [NUM_CH-1:0] chan_odd;
  logic [NUM_CH*2-1:0] chan_mc;
  logic xfer_start;
  logic [CH_W-1:0] xfer_chan;
  logic [PKT_W-1:0] xfer_pkts;
  logic sof;
  logic [FN_W-1:0] frame_num;
  logic tx_done;
  logic tok_valid;
  logic [CH_W-1:0] tok_chan;
  logic [1:0] tok_idx;
  logic xfer_cmpl;
  logic [CH_W-1:0] cmpl_chan;
  logic q_full, wr_err;

  always #4 clk = ~clk;

  periodic_req_queue #(.NUM_CH(NUM_CH), .CH_W(CH_W), .PKT_W(PKT_W), .FN_W(FN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .wr_chan(wr_chan), .chan_odd(chan_odd), .chan_mc(chan_mc),
    .xfer_start(xfer_start), .xfer_chan(xfer_chan), .xfer_pkts(xfer_pkts),
    .sof(sof), .frame_num(frame_num), .tx_done(tx_done),
    .tok_valid(tok_valid), .tok_chan(tok_chan), .tok_idx(tok_idx),
    .xfer_cmpl(xfer_cmpl), .cmpl_chan(cmpl_chan), .q_full(q_full), .wr_err(wr_err)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit live    = 1'b0;
  bit auto_ack = 1'b1;
  bit finished = 1'b0;
  logic [3:0] exp_q [$];
  logic [CH_W-1:0] got_cmpl [$];
  int err_cnt = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: scoreboard compare, acknowledge, record completions and errors
  initial begin
    forever begin
      @(negedge clk);
      if (live) begin
        if (xfer_cmpl) got_cmpl.push_back(cmpl_chan);
        if (wr_err) err_cnt++;
        if (auto_ack) begin
          if (tok_valid) begin
            if (exp_q.size() == 0) begin
              check(1'b0, "R5 unexpected token", int'({tok_chan, tok_idx}), -1);
            end else begin
              logic [3:0] e;
              e = exp_q.pop_front();
              check({tok_chan, tok_idx} == e, "R4 R6 token chan/idx",
                    int'({tok_chan, tok_idx}), int'(e));
            end
            tx_done = 1'b1;
          end else begin
            tx_done = 1'b0;
          end
        end
      end
    end
  end

  task automatic exp_tok(input int ch, input int idx);
    exp_q.push_back({ch[1:0], idx[1:0]});
  endtask

  task automatic wr_pkt(input int ch, input int nwords);
    for (int i = 0; i < nwords; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_last  = (i == nwords - 1);
      wr_chan  = ch[CH_W-1:0];
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic start(input int ch, input int pkts);
    @(negedge clk);
    xfer_start = 1'b1;
    xfer_chan  = ch[CH_W-1:0];
    xfer_pkts  = pkts[PKT_W-1:0];
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  task automatic do_sof(input int fn);
    @(negedge clk);
    sof = 1'b1;
    frame_num = fn[FN_W-1:0];
    @(negedge clk);
    sof = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic sb_drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    check(tok_valid == 1'b0, tag, tok_valid, 0);
  endtask

  task automatic cmpl_expect(input string tag, input int n, input int ch);
    check(got_cmpl.size() == n, tag, got_cmpl.size(), n);
    if (n > 0 && got_cmpl.size() > 0) begin
      logic [CH_W-1:0] c;
      c = got_cmpl.pop_front();
      check(int'(c) == ch, tag, int'(c), ch);
    end
    got_cmpl.delete();
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_last = 1'b0; wr_chan = '0;
    chan_odd = 4'b0011;                       // ch0, ch1 odd; ch2, ch3 even
    chan_mc  = {2'd0, 2'd3, 2'd1, 2'd1};      // ch3=0(as 1), ch2=3, ch1=1, ch0=1
    xfer_start = 1'b0; xfer_chan = '0; xfer_pkts = '0;
    sof = 1'b0; frame_num = '0; tx_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(q_full == 1'b0, "R1 q_full", q_full, 0);
    check(tok_valid == 1'b0, "R1 tok_valid", tok_valid, 0);
    check(xfer_cmpl == 1'b0, "R1 xfer_cmpl", xfer_cmpl, 0);
    check(wr_err == 1'b0, "R1 wr_err", wr_err, 0);
    live = 1'b1;

    // R2 R4 R5 R11: odd channel, two single-packet frames
    start(1, 2);
    wr_pkt(1, 3);
    wr_pkt(1, 2);
    do_sof(2);
    sb_drained("R5 even frame skips odd head");
    exp_tok(1, 0);
    do_sof(3);
    sb_drained("R4 odd frame serves head");
    do_sof(3);
    sb_drained("R11 repeated frame number ignored");
    cmpl_expect("R8 no completion mid transfer", 0, 0);
    exp_tok(1, 0);
    do_sof(5);
    sb_drained("R4 second odd frame");
    cmpl_expect("R8 completion ch1", 1, 1);

    // R6: three-packet group in one frame
    start(2, 3);
    wr_pkt(2, 2); wr_pkt(2, 2); wr_pkt(2, 2);
    exp_tok(2, 0); exp_tok(2, 1); exp_tok(2, 2);
    do_sof(6);
    sb_drained("R6 group of three in one frame");
    cmpl_expect("R8 completion ch2", 1, 2);

    // R6: multi-count 0 acts as 1
    start(3, 2);
    wr_pkt(3, 1); wr_pkt(3, 1);
    exp_tok(3, 0);
    do_sof(8);
    sb_drained("R6 count 0 gives one per frame");
    cmpl_expect("R8 no completion ch3 yet", 0, 0);
    exp_tok(3, 0);
    do_sof(10);
    sb_drained("R6 second frame ch3");
    cmpl_expect("R8 completion ch3", 1, 3);

    // R3: full queue and refused fifth packet end
    wr_pkt(0, 1); wr_pkt(0, 1); wr_pkt(0, 1); wr_pkt(0, 1);
    check(q_full == 1'b1, "R3 q_full at 4", q_full, 1);
    check(err_cnt == 0, "R3 no error before full", err_cnt, 0);
    wr_pkt(0, 1);
    check(err_cnt == 1, "R3 wr_err pulse on full", err_cnt, 1);
    check(q_full == 1'b1, "R3 still full", q_full, 1);
    for (int f = 0; f < 4; f++) begin
      exp_tok(0, 0);
      do_sof(15 + 2 * f);
      if (f == 0) check(q_full == 1'b0, "R3 full clears after pop", q_full, 0);
    end
    sb_drained("R3 four entries served");
    do_sof(23);
    sb_drained("R3 refused entry not stored");
    cmpl_expect("R8 channel without transfer never completes", 0, 0);

    // R5 R9: head-of-line blocking and stray acknowledgement
    wr_pkt(1, 1);
    wr_pkt(2, 1);
    do_sof(24);
    sb_drained("R5 even entry behind odd head not served");
    auto_ack = 1'b0;
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
    @(negedge clk);
    auto_ack = 1'b1;
    exp_tok(1, 0);
    do_sof(25);
    sb_drained("R9 idle ack left head in place");
    exp_tok(2, 0);
    do_sof(26);
    sb_drained("R5 entry behind served next frame");
    cmpl_expect("R9 no completion from stray ack", 0, 0);

    // R10: restart resets the group index
    start(2, 3);
    wr_pkt(2, 1);
    wr_pkt(2, 1);
    start(2, 3);
    wr_pkt(2, 1);
    exp_tok(2, 0); exp_tok(2, 1);
    do_sof(28);
    sb_drained("R10 burst stops at restarted index 0");
    cmpl_expect("R8 no completion after two", 0, 0);
    exp_tok(2, 0);
    do_sof(30);
    sb_drained("R10 restarted group served");
    cmpl_expect("R8 completion after restart", 1, 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule